// File: doc/BRIEF.md
# Contention-Adaptive Lock Acquirer

This block acquires one shared lock word for a single processor core. When the core raises its acquire request, the block reads the lock word again and again as long as the word shows busy. The instant a read shows the word free, it issues an atomic test-and-set in the next cycle. If another agent takes the lock first, the test-and-set fails. The block then stays off the memory port for a retry wait before it goes back to reading.

The retry wait adapts to contention. The first failed attempt of an acquisition waits the current starting delay. Each later failure doubles the wait, up to a ceiling equal to the number of processors that share the lock. When an acquisition succeeds, the starting delay for the next acquisition becomes half of the last delay, and never drops below one cycle. The core holds the grant until it pulses release. The block then clears the lock word with a plain write.

The memory port carries three one-cycle operations: read, test-and-set and clear. `lk_rdata` returns the word's value before the operation, during the cycle the operation is asserted. A test-and-set writes busy and a clear writes free at the closing clock edge. The encoding is 1 = busy, 0 = free.

The states are IDLE, SPIN, ATTEMPT, BACKOFF, HELD and RELEASE. The transitions are:
- IDLE→SPIN on request.
- SPIN→SPIN while the read shows busy.
- SPIN→ATTEMPT when the read shows free.
- ATTEMPT→HELD when the test-and-set returns free.
- ATTEMPT→BACKOFF when the test-and-set returns busy.
- BACKOFF→SPIN when the wait expires.
- HELD→RELEASE on a release pulse.
- RELEASE→IDLE unconditionally.

Top module: `lock_acquirer`

## Requirements
- R1: After reset, `core_grant`, `rel_error`, `lk_rd`, `lk_tas` and `lk_clr` are all 0.
- R2: A read that returns busy (1) is followed in the next cycle by another read and no test-and-set.
- R3: A read that returns free (0) is followed in the very next cycle by a test-and-set.
- R4: `core_grant` rises only in the cycle after a test-and-set returned free. It then stays high until the cycle after a `core_release` pulse.
- R5: A `core_release` pulse while granted gives exactly one cycle of `lk_clr` in the next cycle, and `core_grant` is low in that cycle.
- R6: After a failed test-and-set (returned 1), exactly W cycles with no memory operation follow, then a read, where W is the current retry wait.
- R7: Within one acquisition, each failure after the first uses twice the previous wait, limited to NPROC.
- R8: The first failure of an acquisition waits the starting delay. The starting delay is 1 after reset. After each successful acquisition it becomes max(1, floor(last delay / 2)).
- R9: A `core_release` pulse while not granted produces no clear. It sets `rel_error` in the next cycle, and `rel_error` then stays set until reset.
- R10: At most one of `lk_rd`, `lk_tas` and `lk_clr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core asks for the lock |
| core_release | input | 1 | One-cycle pulse to give the lock back |
| core_grant | output | 1 | Lock is held for the core |
| rel_error | output | 1 | Sticky: a release arrived while not holding |
| lk_rd | output | 1 | Read the lock word |
| lk_tas | output | 1 | Atomic test-and-set of the lock word |
| lk_clr | output | 1 | Write free to the lock word |
| lk_rdata | input | 1 | Lock word value before the current operation (1 = busy) |

## Verification
Every result falls due at a fixed distance from its cause:
- A follow-up read or test-and-set comes one cycle after the read that decides it.
- The grant comes one cycle after a winning test-and-set.
- The clear and the drop of the grant come one cycle after the release pulse.
- The sticky error comes one cycle after a stray release.
- After a failed attempt, the next read comes exactly W+1 cycles later.

The bench samples on the falling edge and keeps the previous cycle's port values. Each expectation is checked in exactly the cycle it falls due. A bench model of the starting delay, the doubling and the ceiling supplies W for each failure.

// File: rtl/lock_acq_pkg.sv
package lock_acq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPIN,
        ST_ATTEMPT,
        ST_BACKOFF,
        ST_HELD,
        ST_RELEASE
    } acq_state_e;
endpackage

// File: rtl/lock_backoff_delay.sv
// Holds the adaptive retry delay: doubles per collision, capped, halved on win.
module lock_backoff_delay #(
    parameter int unsigned NPROC = 8,
    parameter int unsigned DW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fail_i,
    input  logic          win_i,
    output logic [DW-1:0] wait_o
);
    localparam logic [DW:0]   CAP  = (DW+1)'(NPROC);
    localparam logic [DW-1:0] ONE  = DW'(1);

    logic [DW-1:0] dly_q;
    logic          first_q;
    logic [DW:0]   doubled;
    logic [DW-1:0] grown;
    logic [DW-1:0] halved;

    always_comb begin
        doubled = {dly_q, 1'b0};
        grown   = (doubled > CAP) ? CAP[DW-1:0] : doubled[DW-1:0];
        wait_o  = first_q ? dly_q : grown;
        halved  = (dly_q >> 1) == '0 ? ONE : (dly_q >> 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q   <= ONE;
            first_q <= 1'b1;
        end else if (fail_i) begin
            dly_q   <= wait_o;
            first_q <= 1'b0;
        end else if (win_i) begin
            dly_q   <= halved;
            first_q <= 1'b1;
        end
    end

    a_r7_delay_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_q >= ONE) && ({1'b0, dly_q} <= CAP));
    a_r7_delay_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && !first_q) |=> dly_q >= $past(dly_q));
    a_r8_delay_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        win_i |=> dly_q <= $past(dly_q));
endmodule

// File: rtl/lock_wait_timer.sv
// Down-counter that marks the last cycle of a retry wait.
module lock_wait_timer #(
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] len_i,
    output logic          last_o
);
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - DW'(1);
    end

    assign last_o = (cnt_q == DW'(1));

    a_r6_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i != '0) |=> cnt_q != '0);
endmodule

// File: rtl/lock_acquirer.sv
module lock_acquirer #(
    parameter int unsigned NPROC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_req,
    input  logic core_release,
    output logic core_grant,
    output logic rel_error,
    output logic lk_rd,
    output logic lk_tas,
    output logic lk_clr,
    input  logic lk_rdata
);
    import lock_acq_pkg::*;

    localparam int unsigned DW = $clog2(NPROC + 1);

    acq_state_e    state_q, state_d;
    logic          tas_fail, tas_win, wait_last, err_q;
    logic [DW-1:0] wait_len;

    assign tas_fail = (state_q == ST_ATTEMPT) &&  lk_rdata;
    assign tas_win  = (state_q == ST_ATTEMPT) && !lk_rdata;

    lock_backoff_delay #(.NPROC(NPROC), .DW(DW)) delay_i (
        .clk(clk), .rst_n(rst_n), .fail_i(tas_fail), .win_i(tas_win), .wait_o(wait_len)
    );

    lock_wait_timer #(.DW(DW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load_i(tas_fail), .len_i(wait_len), .last_o(wait_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (core_release && state_q != ST_HELD)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (core_req) state_d = ST_SPIN;
            ST_SPIN:    if (!lk_rdata) state_d = ST_ATTEMPT;
            ST_ATTEMPT: state_d = lk_rdata ? ST_BACKOFF : ST_HELD;
            ST_BACKOFF: if (wait_last) state_d = ST_SPIN;
            ST_HELD:    if (core_release) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        lk_rd      = (state_q == ST_SPIN);
        lk_tas     = (state_q == ST_ATTEMPT);
        lk_clr     = (state_q == ST_RELEASE);
        core_grant = (state_q == ST_HELD);
        rel_error  = err_q;
    end

    a_r10_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_rd, lk_tas, lk_clr}));
    a_r2_busy_keeps_reading: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rd && lk_rdata) |=> (lk_rd && !lk_tas));
    a_r3_free_triggers_tas: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rd && !lk_rdata) |=> lk_tas);
    a_r4_grant_after_win: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_grant) |-> $past(lk_tas && !lk_rdata));
    a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (core_grant && core_release) |=> (lk_clr && !core_grant));
    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rel_error |=> rel_error);
endmodule

// File: tb/lock_acquirer_tb_top.sv
module lock_acquirer_tb_top;
    localparam int NP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 1'b0, core_release = 1'b0;
    logic core_grant, rel_error, lk_rd, lk_tas, lk_clr, lk_rdata;

    logic lk = 1'b0;
    logic tb_busy = 1'b0;
    int   coll_left = 0;
    logic other_hold;

    int errors = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign other_hold = lk_tas ? (coll_left != 0) : tb_busy;
    assign lk_rdata   = lk | other_hold;

    always @(posedge clk) begin
        if (!rst_n) lk <= 1'b0;
        else if (lk_clr) lk <= 1'b0;
        else if (lk_tas && !other_hold) lk <= 1'b1;
    end

    lock_acquirer #(.NPROC(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_release(core_release),
        .core_grant(core_grant), .rel_error(rel_error), .lk_rd(lk_rd), .lk_tas(lk_tas),
        .lk_clr(lk_clr), .lk_rdata(lk_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int next_wait(input int cur, input bit first);
        int d;
        if (first) return cur;
        d = cur * 2;
        return (d > NP) ? NP : d;
    endfunction

    function automatic int next_start(input int cur);
        return (cur / 2 < 1) ? 1 : cur / 2;
    endfunction

    // model of the delay, and last-cycle port values
    int  m_cur = 1;
    bit  m_first = 1;
    bit  p_valid = 0;
    bit  p_rd, p_tas, p_clr, p_rdata, p_grant, p_rel;
    bit  pend = 0;
    int  gcnt, gexp;
    bit  gfirst;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_valid = 0;
            pend = 0;
            m_cur = 1;
            m_first = 1;
        end else begin
            chk((lk_rd + lk_tas + lk_clr) <= 1, "R10 ops per cycle", lk_rd + lk_tas + lk_clr, 1);
            if (p_valid) begin
                if (p_rd && p_rdata)
                    chk(lk_rd && !lk_tas, "R2 read again while busy", {lk_rd, lk_tas}, 2);
                if (p_rd && !p_rdata)
                    chk(lk_tas, "R3 tas after free read", lk_tas, 1);
                if (p_tas && !p_rdata) begin
                    chk(core_grant, "R4 grant after win", core_grant, 1);
                    m_cur = next_start(m_cur);
                    m_first = 1;
                end
                if (p_tas && p_rdata) begin
                    gexp = next_wait(m_cur, m_first);
                    gfirst = m_first;
                    m_cur = gexp;
                    m_first = 0;
                    pend = 1;
                    gcnt = 0;
                end
                if (pend) begin
                    if (lk_rd) begin
                        chk(gcnt == gexp, gfirst ? "R8 start delay" : "R7 doubled delay", gcnt, gexp);
                        pend = 0;
                    end else if (lk_tas || lk_clr) begin
                        chk(0, "R6 op during wait", gcnt, gexp);
                        pend = 0;
                    end else begin
                        gcnt++;
                        if (gcnt > gexp) begin
                            chk(0, "R6 wait too long", gcnt, gexp);
                            pend = 0;
                        end
                    end
                end
                if (p_grant && !p_rel)
                    chk(core_grant, "R4 grant held", core_grant, 1);
                if (p_grant && p_rel)
                    chk(lk_clr && !core_grant, "R5 clear on release", {lk_clr, core_grant}, 2);
                if (p_clr)
                    chk(!lk_clr, "R5 single clear", lk_clr, 0);
                if (!p_grant && p_rel)
                    chk(rel_error && !lk_clr, "R9 stray release", {rel_error, lk_clr}, 2);
                if (core_grant && !p_grant)
                    chk(p_tas && !p_rdata, "R4 grant source", {p_tas, p_rdata}, 2);
            end
            p_rd = lk_rd; p_tas = lk_tas; p_clr = lk_clr; p_rdata = lk_rdata;
            p_grant = core_grant; p_rel = core_release; p_valid = 1;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic acquire(input int ncoll, input int busy_pct, input int hold);
        int guard = 0;
        coll_left = ncoll;
        core_req = 1'b1;
        tb_busy = ($urandom % 100) < busy_pct;
        while (!core_grant && guard < 2000) begin
            cyc();
            if (p_tas && coll_left > 0) coll_left--;
            tb_busy = ($urandom % 100) < busy_pct;
            guard++;
        end
        core_req = 1'b0;
        tb_busy = 1'b0;
        for (int i = 0; i < hold; i++) cyc();
        core_release = 1'b1;
        cyc();
        core_release = 1'b0;
        cyc();
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: grant actual=%0d expected=1", core_grant);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) cyc();
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk(!core_grant && !rel_error && !lk_rd && !lk_tas && !lk_clr, "R1 reset outputs",
            {core_grant, rel_error, lk_rd, lk_tas, lk_clr}, 0);
        cyc();
        // R9 stray release while idle
        core_release = 1'b1;
        cyc();
        core_release = 1'b0;
        cyc();
        // directed: no contention, then long collision run to reach cap
        acquire(0, 0, 2);
        acquire(6, 0, 1);
        acquire(0, 0, 1);
        acquire(0, 0, 1);
        acquire(0, 0, 1);
        acquire(2, 50, 3);
        // stray release while another acquisition is idle again
        core_release = 1'b1;
        cyc();
        core_release = 1'b0;
        cyc();
        // random mix
        for (int k = 0; k < 60; k++)
            acquire($urandom % 6, $urandom % 70, 1 + $urandom % 4);
        cyc();
        chk(rel_error, "R9 error stays set", rel_error, 1);
        finish_run();
    end
endmodule